// File: doc/BRIEF.md
# Boot Table Interpreter Engine

The engine walks a table of fixed-length boot instructions held in memory and carries them out one at a time. Its state is a 32-bit accumulator and a byte offset into the table. Each instruction can read or write a memory word, read or write a byte-wide I/O port, read or write a configuration register through an address/data port pair, merge constants into the accumulator, or branch relative to the following instruction. A prefix opcode reuses the accumulator as the data operand of the instruction it wraps.

Software or a reset sequencer gives a table base address and a table length in bytes, then pulses start. The engine reports completion with a one-cycle done pulse. At that point the final accumulator is presented, and an error flag shows whether a branch left the table. Each of the three external interfaces holds its request until the responder acknowledges it. Only one interface is active at any time.

Top module: `boot_table_engine`

## Requirements
- R1: An instruction is 9 bytes at table offset k: opcode byte at k, OP1 at k+1, OP2 at k+5. Each read on the memory interface returns the little-endian 32-bit word starting at the requested byte address. The opcode is the low byte of the word read at k.
- R2: Opcode 0x01 performs three configuration writes, in this order: OP2 to the address port (sel 0), OP1 to the data port (sel 1), then zero to the address port.
- R3: Opcode 0x05 writes OP2 to the address port, then reads the data port (sel 1) into the accumulator.
- R4: Opcode 0x02 writes the low byte of OP1 to port OP2[15:0]. Opcode 0x08 reads port OP2[15:0] and loads the byte, zero-extended, into the accumulator.
- R5: Opcode 0x03 writes OP1 to memory address OP2. Opcode 0x09 loads the accumulator from memory address OP2.
- R6: Opcode 0x06 sets the accumulator to (accumulator AND OP2) OR OP1.
- R7: Opcode 0x07 always branches. Opcode 0x04 branches only when the accumulator differs from OP2. The new offset is the instruction's own offset + 9 + OP1, modulo 2^32, so a backward branch uses a negative OP1.
- R8: Prefix 0xE1 runs the opcode found in the low byte of OP2. For that opcode, OP2 is replaced by the original OP1 and OP1 is replaced by the accumulator.
- R9: Opcode 0xEE ends the run. Completion is a single-cycle done pulse, with acc_o holding the final accumulator. A new start clears the accumulator to zero.
- R10: Before each instruction, the run ends without error if fewer than 9 bytes remain between the current offset and the table length. A branch target equal to the length therefore ends the run cleanly.
- R11: An opcode not listed here causes no bus activity, leaves the accumulator unchanged, and advances by 9 bytes.
- R12: A branch whose target offset is above the table length ends the run at once, with err_o set and the accumulator intact. err_o stays set until the next start.
- R13: At most one of mem_req_o, io_req_o and cfg_req_o is high at any time, and no request is raised while busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run (sampled while idle) |
| base_i | input | ADDR_W | Byte address of the table |
| len_i | input | 32 | Table length in bytes |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last run ended on an out-of-table branch |
| acc_o | output | 32 | Accumulator |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data (little-endian word) |
| mem_ack_i | input | 1 | Memory acknowledge |
| io_req_o | output | 1 | Port request |
| io_we_o | output | 1 | Port write |
| io_addr_o | output | PORT_W | Port number |
| io_wdata_o | output | 8 | Port write byte |
| io_rdata_i | input | 8 | Port read byte |
| io_ack_i | input | 1 | Port acknowledge |
| cfg_req_o | output | 1 | Configuration request |
| cfg_we_o | output | 1 | Configuration write |
| cfg_sel_o | output | 1 | 0 = address port, 1 = data port |
| cfg_wdata_o | output | 32 | Configuration write data |
| cfg_rdata_i | input | 32 | Configuration read data |
| cfg_ack_i | input | 1 | Configuration acknowledge |

## Verification
A wrong offset or a wrong operand latch shows up at the ports within one instruction. The next port or configuration transaction then carries a wrong address or data byte, or a transaction appears that the scoreboard did not expect, such as the write in a skipped branch slot. A corrupted accumulator can stay hidden until it is consumed. It becomes visible when a later conditional branch resolves the wrong way, when a prefixed instruction writes it out, or, at the latest, on acc_o at the done pulse. Programs are therefore built so that each accumulator value is consumed by a later instruction.

// File: rtl/boot_pkg.sv
package boot_pkg;
  localparam int DATA_W      = 32;
  localparam int INSTR_BYTES = 9;
  localparam int OP1_OFS     = 1;
  localparam int OP2_OFS     = 5;

  localparam logic [7:0] OP_CFG_WR = 8'h01;
  localparam logic [7:0] OP_IO_WR  = 8'h02;
  localparam logic [7:0] OP_MEM_WR = 8'h03;
  localparam logic [7:0] OP_BNE    = 8'h04;
  localparam logic [7:0] OP_CFG_RD = 8'h05;
  localparam logic [7:0] OP_ANDOR  = 8'h06;
  localparam logic [7:0] OP_BRA    = 8'h07;
  localparam logic [7:0] OP_IO_RD  = 8'h08;
  localparam logic [7:0] OP_MEM_RD = 8'h09;
  localparam logic [7:0] OP_PREFIX = 8'hE1;
  localparam logic [7:0] OP_END    = 8'hEE;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CHECK, ST_F_OPC, ST_F_OP1, ST_F_OP2, ST_EXEC,
    ST_MEM_W, ST_MEM_R, ST_IO_W, ST_IO_R,
    ST_CFG_A, ST_CFG_D, ST_CFG_Z, ST_NEXT, ST_FIN
  } state_e;
endpackage

// File: rtl/boot_decode.sv
module boot_decode
  import boot_pkg::*;
(
  input  logic [7:0]        opc_i,
  input  logic [DATA_W-1:0] op1_i,
  input  logic [DATA_W-1:0] op2_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic [7:0]        eff_opc_o,
  output logic [DATA_W-1:0] eff_a_o,
  output logic [DATA_W-1:0] eff_b_o
);
  // prefix: inner opcode from OP2, operands shift by one slot
  always_comb begin
    if (opc_i == OP_PREFIX) begin
      eff_opc_o = op2_i[7:0];
      eff_a_o   = acc_i;
      eff_b_o   = op1_i;
    end else begin
      eff_opc_o = opc_i;
      eff_a_o   = op1_i;
      eff_b_o   = op2_i;
    end
  end
endmodule

// File: rtl/boot_branch.sv
module boot_branch
  import boot_pkg::*;
(
  input  logic [DATA_W-1:0] off_i,
  input  logic [DATA_W-1:0] len_i,
  input  logic [DATA_W-1:0] rel_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] cmp_i,
  output logic [DATA_W-1:0] target_o,
  output logic              oor_o,
  output logic              differ_o
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(INSTR_BYTES);

  assign target_o = off_i + STEP + rel_i;
  assign oor_o    = target_o > len_i;
  assign differ_o = acc_i != cmp_i;
endmodule

// File: rtl/boot_table_engine.sv
module boot_table_engine
  import boot_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PORT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [31:0]       len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [31:0]       acc_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_ack_i,
  output logic              io_req_o,
  output logic              io_we_o,
  output logic [PORT_W-1:0] io_addr_o,
  output logic [7:0]        io_wdata_o,
  input  logic [7:0]        io_rdata_i,
  input  logic              io_ack_i,
  output logic              cfg_req_o,
  output logic              cfg_we_o,
  output logic              cfg_sel_o,
  output logic [31:0]       cfg_wdata_o,
  input  logic [31:0]       cfg_rdata_i,
  input  logic              cfg_ack_i
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(INSTR_BYTES);

  state_e              state_q;
  logic [ADDR_W-1:0]   base_q;
  logic [DATA_W-1:0]   len_q, off_q, acc_q, op1_q, op2_q;
  logic [7:0]          opc_q;
  logic                err_q;

  logic [7:0]          eff_opc;
  logic [DATA_W-1:0]   eff_a, eff_b, target;
  logic                oor, differ;

  boot_decode u_decode (
    .opc_i(opc_q), .op1_i(op1_q), .op2_i(op2_q), .acc_i(acc_q),
    .eff_opc_o(eff_opc), .eff_a_o(eff_a), .eff_b_o(eff_b)
  );

  boot_branch u_branch (
    .off_i(off_q), .len_i(len_q), .rel_i(eff_a), .acc_i(acc_q), .cmp_i(eff_b),
    .target_o(target), .oor_o(oor), .differ_o(differ)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      len_q   <= '0;
      off_q   <= '0;
      acc_q   <= '0;
      op1_q   <= '0;
      op2_q   <= '0;
      opc_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          base_q  <= base_i;
          len_q   <= len_i;
          off_q   <= '0;
          acc_q   <= '0;
          err_q   <= 1'b0;
          state_q <= ST_CHECK;
        end
        ST_CHECK: state_q <= (len_q - off_q < STEP) ? ST_FIN : ST_F_OPC;
        ST_F_OPC: if (mem_ack_i) begin
          opc_q   <= mem_rdata_i[7:0];
          state_q <= ST_F_OP1;
        end
        ST_F_OP1: if (mem_ack_i) begin
          op1_q   <= mem_rdata_i;
          state_q <= ST_F_OP2;
        end
        ST_F_OP2: if (mem_ack_i) begin
          op2_q   <= mem_rdata_i;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          opc_q <= eff_opc;
          op1_q <= eff_a;
          op2_q <= eff_b;
          unique case (eff_opc)
            OP_CFG_WR, OP_CFG_RD: state_q <= ST_CFG_A;
            OP_IO_WR:  state_q <= ST_IO_W;
            OP_IO_RD:  state_q <= ST_IO_R;
            OP_MEM_WR: state_q <= ST_MEM_W;
            OP_MEM_RD: state_q <= ST_MEM_R;
            OP_END:    state_q <= ST_FIN;
            OP_ANDOR: begin
              acc_q   <= (acc_q & eff_b) | eff_a;
              state_q <= ST_NEXT;
            end
            OP_BRA, OP_BNE: begin
              if (eff_opc == OP_BNE && !differ) begin
                state_q <= ST_NEXT;
              end else if (oor) begin
                err_q   <= 1'b1;
                state_q <= ST_FIN;
              end else begin
                off_q   <= target;
                state_q <= ST_CHECK;
              end
            end
            default: state_q <= ST_NEXT;
          endcase
        end
        ST_MEM_W: if (mem_ack_i) state_q <= ST_NEXT;
        ST_MEM_R: if (mem_ack_i) begin
          acc_q   <= mem_rdata_i;
          state_q <= ST_NEXT;
        end
        ST_IO_W: if (io_ack_i) state_q <= ST_NEXT;
        ST_IO_R: if (io_ack_i) begin
          acc_q   <= {{(DATA_W-8){1'b0}}, io_rdata_i};
          state_q <= ST_NEXT;
        end
        ST_CFG_A: if (cfg_ack_i) state_q <= ST_CFG_D;
        ST_CFG_D: if (cfg_ack_i) begin
          if (opc_q == OP_CFG_RD) begin
            acc_q   <= cfg_rdata_i;
            state_q <= ST_NEXT;
          end else begin
            state_q <= ST_CFG_Z;
          end
        end
        ST_CFG_Z: if (cfg_ack_i) state_q <= ST_NEXT;
        ST_NEXT: begin
          off_q   <= off_q + STEP;
          state_q <= ST_CHECK;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = state_q != ST_IDLE;
  assign done_o = state_q == ST_FIN;
  assign err_o  = err_q;
  assign acc_o  = acc_q;

  assign mem_req_o = state_q inside {ST_F_OPC, ST_F_OP1, ST_F_OP2, ST_MEM_W, ST_MEM_R};
  assign mem_we_o  = state_q == ST_MEM_W;
  always_comb begin
    unique case (state_q)
      ST_F_OP1: mem_addr_o = base_q + ADDR_W'(off_q) + ADDR_W'(OP1_OFS);
      ST_F_OP2: mem_addr_o = base_q + ADDR_W'(off_q) + ADDR_W'(OP2_OFS);
      ST_MEM_W, ST_MEM_R: mem_addr_o = op2_q[ADDR_W-1:0];
      default:  mem_addr_o = base_q + ADDR_W'(off_q);
    endcase
  end
  assign mem_wdata_o = op1_q;

  assign io_req_o   = state_q inside {ST_IO_W, ST_IO_R};
  assign io_we_o    = state_q == ST_IO_W;
  assign io_addr_o  = op2_q[PORT_W-1:0];
  assign io_wdata_o = op1_q[7:0];

  assign cfg_req_o   = state_q inside {ST_CFG_A, ST_CFG_D, ST_CFG_Z};
  assign cfg_we_o    = !(state_q == ST_CFG_D && opc_q == OP_CFG_RD);
  assign cfg_sel_o   = state_q == ST_CFG_D;
  assign cfg_wdata_o = (state_q == ST_CFG_A) ? op2_q :
                       (state_q == ST_CFG_D) ? op1_q : '0;

  // R13: one interface at a time, nothing while idle
  a_r13_one_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_req_o, io_req_o, cfg_req_o}));
  a_r13_req_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || io_req_o || cfg_req_o) |-> busy_o);
  // R2: a data-port write is always followed by the zero address write
  a_r2_cfg_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_o && cfg_ack_i && cfg_we_o && cfg_sel_o) |=>
      (cfg_req_o && cfg_we_o && !cfg_sel_o && cfg_wdata_o == '0));
  // R9: done is a single-cycle pulse; accumulator frozen while idle
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_acc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(acc_o));
  // R12: error only appears together with completion
  a_r12_err_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o);
endmodule

// File: tb/boot_table_engine_bench.sv
module boot_table_engine_bench;
  localparam int BASE = 'h40;
  localparam int K_MEMW = 0, K_IOW = 1, K_IOR = 2, K_CFGW = 3, K_CFGR = 4;

  typedef struct {
    int          kind;
    logic [31:0] addr;
    logic [31:0] data;
    logic        sel;
    string       tag;
  } txn_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start = 1'b0;
  logic [31:0] base = BASE, len = '0;
  logic        busy, done, err;
  logic [31:0] acc;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        io_req, io_we, io_ack = 1'b0;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata, io_rdata = '0;
  logic        cfg_req, cfg_we, cfg_sel, cfg_ack = 1'b0;
  logic [31:0] cfg_wdata, cfg_rdata = '0;

  boot_table_engine u_boot_table_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base), .len_i(len),
    .busy_o(busy), .done_o(done), .err_o(err), .acc_o(acc),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .io_req_o(io_req), .io_we_o(io_we), .io_addr_o(io_addr),
    .io_wdata_o(io_wdata), .io_rdata_i(io_rdata), .io_ack_i(io_ack),
    .cfg_req_o(cfg_req), .cfg_we_o(cfg_we), .cfg_sel_o(cfg_sel),
    .cfg_wdata_o(cfg_wdata), .cfg_rdata_i(cfg_rdata), .cfg_ack_i(cfg_ack)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0]  mem_m [256];
  logic [31:0] cfg_addr_m = '0;
  txn_t        exp_q[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic push(input int kind, input logic [31:0] addr, input logic [31:0] data,
                      input logic sel, input string tag);
    txn_t t;
    t.kind = kind; t.addr = addr; t.data = data; t.sel = sel; t.tag = tag;
    exp_q.push_back(t);
  endtask

  task automatic observe(input int kind, input logic [31:0] addr, input logic [31:0] data,
                         input logic sel);
    txn_t t;
    if (exp_q.size() == 0) begin
      n_cmp++; n_bad++;
      $display("FAIL unexpected transaction: actual kind %0d addr %h data %h expected none",
               kind, addr, data);
      return;
    end
    t = exp_q.pop_front();
    check({t.tag, " kind"}, 32'(kind), 32'(t.kind));
    if (kind == K_CFGW || kind == K_CFGR) check({t.tag, " sel"}, 32'(sel), 32'(t.sel));
    if (kind != K_CFGW && kind != K_CFGR) check({t.tag, " addr"}, addr, t.addr);
    if (kind != K_IOR && kind != K_CFGR) check({t.tag, " data"}, data, t.data);
  endtask

  // response models and monitor
  always @(negedge clk) begin
    mem_ack = 1'b0; io_ack = 1'b0; cfg_ack = 1'b0;
    if (rst_n && mem_req) begin
      if (mem_we) begin
        for (int i = 0; i < 4; i++) mem_m[8'(mem_addr + 32'(i))] = mem_wdata[8*i +: 8];
        observe(K_MEMW, mem_addr, mem_wdata, 1'b0);
      end else begin
        for (int i = 0; i < 4; i++) mem_rdata[8*i +: 8] = mem_m[8'(mem_addr + 32'(i))];
      end
      mem_ack = 1'b1;
    end
    if (rst_n && io_req) begin
      if (io_we) observe(K_IOW, 32'(io_addr), 32'(io_wdata), 1'b0);
      else begin
        io_rdata = io_addr[7:0] ^ 8'h5D;
        observe(K_IOR, 32'(io_addr), 32'h0, 1'b0);
      end
      io_ack = 1'b1;
    end
    if (rst_n && cfg_req) begin
      if (cfg_we) begin
        if (!cfg_sel) cfg_addr_m = cfg_wdata;
        observe(K_CFGW, 32'h0, cfg_wdata, cfg_sel);
      end else begin
        cfg_rdata = cfg_addr_m ^ 32'h5A5A_0000;
        observe(K_CFGR, 32'h0, 32'h0, cfg_sel);
      end
      cfg_ack = 1'b1;
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
  endtask

  task automatic put(input int idx, input logic [7:0] opc, input logic [31:0] op1,
                     input logic [31:0] op2);
    int a;
    a = BASE + idx * 9;
    mem_m[a] = opc;
    for (int i = 0; i < 4; i++) begin
      mem_m[a + 1 + i] = op1[8*i +: 8];
      mem_m[a + 5 + i] = op2[8*i +: 8];
    end
  endtask

  task automatic run(input string tag, input logic [31:0] l, input logic [31:0] acc_exp,
                     input logic err_exp);
    int cyc;
    @(negedge clk);
    len = l; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    check({tag, " done seen"}, 32'(done), 32'h1);
    check({tag, " acc (R9)"}, acc, acc_exp);
    check({tag, " err (R12)"}, 32'(err), 32'(err_exp));
    check({tag, " pending transactions"}, 32'(exp_q.size()), 32'h0);
    exp_q.delete();
    @(negedge clk);
    check({tag, " done single pulse R9"}, 32'(done), 32'h0);
    check({tag, " idle after done R13"}, 32'(busy), 32'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : driver
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset busy", 32'(busy), 32'h0);
    check("reset done R9", 32'(done), 32'h0);
    check("reset err R12", 32'(err), 32'h0);
    check("reset acc R9", acc, 32'h0);
    check("reset req R13", 32'({mem_req, io_req, cfg_req}), 32'h0);

    // R2/R3/R1: config poke then peek
    clear_mem();
    put(0, 8'h01, 32'hDEAD_BEEF, 32'h8000_0880);
    put(1, 8'h05, 32'h0, 32'h8000_1000);
    put(2, 8'hEE, 32'h0, 32'h0);
    push(K_CFGW, 0, 32'h8000_0880, 1'b0, "R2 addr");
    push(K_CFGW, 0, 32'hDEAD_BEEF, 1'b1, "R2 data");
    push(K_CFGW, 0, 32'h0, 1'b0, "R2 close");
    push(K_CFGW, 0, 32'h8000_1000, 1'b0, "R3 addr");
    push(K_CFGR, 0, 32'h0, 1'b1, "R3 read");
    run("R3 cfg", 27, 32'h8000_1000 ^ 32'h5A5A_0000, 1'b0);

    // R4/R6: port out, port in, and/or
    clear_mem();
    put(0, 8'h02, 32'h0000_01A5, 32'h0000_0080);
    put(1, 8'h08, 32'h0, 32'h0000_0061);
    put(2, 8'h06, 32'h0000_0500, 32'h0000_00F0);
    put(3, 8'hEE, 32'h0, 32'h0);
    push(K_IOW, 32'h80, 32'hA5, 1'b0, "R4 out");
    push(K_IOR, 32'h61, 32'h0, 1'b0, "R4 in");
    run("R6 andor", 36, 32'h0000_0530, 1'b0);

    // R5/R7: memory poke/peek, BNE not taken and taken
    clear_mem();
    put(0, 8'h03, 32'hCAFE_F00D, 32'h0000_00C0);
    put(1, 8'h09, 32'h0, 32'h0000_00C0);
    put(2, 8'h04, 32'd9, 32'hCAFE_F00D);
    put(3, 8'h06, 32'h0000_0011, 32'h0);
    put(4, 8'h04, 32'd9, 32'h0);
    put(5, 8'h02, 32'h1, 32'h0000_0099);
    put(6, 8'hEE, 32'h0, 32'h0);
    push(K_MEMW, 32'hC0, 32'hCAFE_F00D, 1'b0, "R5 poke");
    run("R7 bne", 63, 32'h0000_0011, 1'b0);

    // R7: forward and backward BRA
    clear_mem();
    put(0, 8'h07, 32'd9, 32'h0);
    put(1, 8'hEE, 32'h0, 32'h0);
    put(2, 8'h02, 32'h0000_0007, 32'h0000_0033);
    put(3, 8'h07, 32'hFFFF_FFE5, 32'h0);
    push(K_IOW, 32'h33, 32'h07, 1'b0, "R7 bra");
    run("R7 bra back", 36, 32'h0, 1'b0);

    // R8: prefix substitutes accumulator
    clear_mem();
    put(0, 8'h06, 32'h0000_0077, 32'h0);
    put(1, 8'hE1, 32'h0000_0050, 32'h0000_0002);
    put(2, 8'hE1, 32'h8000_0044, 32'h0000_0001);
    put(3, 8'hEE, 32'h0, 32'h0);
    push(K_IOW, 32'h50, 32'h77, 1'b0, "R8 prefixed out");
    push(K_CFGW, 0, 32'h8000_0044, 1'b0, "R8 prefixed cfg addr");
    push(K_CFGW, 0, 32'h0000_0077, 1'b1, "R8 prefixed cfg data");
    push(K_CFGW, 0, 32'h0, 1'b0, "R8 prefixed cfg close");
    run("R8 prefix", 36, 32'h0000_0077, 1'b0);

    // R11: unknown opcode is a no-op
    clear_mem();
    put(0, 8'h06, 32'h0000_0042, 32'h0);
    put(1, 8'h5A, 32'h1234_5678, 32'h0000_00C4);
    put(2, 8'hEE, 32'h0, 32'h0);
    run("R11 unknown", 27, 32'h0000_0042, 1'b0);

    // R10: length exhaustion without END
    clear_mem();
    put(0, 8'h06, 32'h0000_0009, 32'h0);
    put(1, 8'h02, 32'h0000_0001, 32'h0000_0010);
    put(2, 8'h02, 32'h0000_0002, 32'h0000_0011);
    push(K_IOW, 32'h10, 32'h01, 1'b0, "R10 last in table");
    run("R10 exhaust", 26, 32'h0000_0009, 1'b0);

    // R12: branch beyond table
    clear_mem();
    put(0, 8'h06, 32'h0000_0003, 32'h0);
    put(1, 8'h07, 32'h0000_0100, 32'h0);
    put(2, 8'hEE, 32'h0, 32'h0);
    run("R12 oor", 27, 32'h0000_0003, 1'b1);

    // R9/R10: too-short table, err cleared, acc cleared on start
    clear_mem();
    run("R10 short", 5, 32'h0, 1'b0);

    // R10: branch landing exactly on length ends cleanly
    clear_mem();
    put(0, 8'h07, 32'd9, 32'h0);
    put(1, 8'h02, 32'h1, 32'h0000_0044);
    run("R10 edge target", 18, 32'h0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule